// File: doc/BRIEF.md
# Sub-warp Issue Scheduler

This block chooses the group of threads that issues next from one warp on a single SIMT pipeline partition. Each lane keeps its own program counter and a run state: running, waiting, or finished. In every cycle the block looks at the running lanes and finds the lowest program counter among them. All running lanes that hold that value form the active mask. One instruction at that counter is issued for that mask, and the block never issues more than one per cycle.

The groups are not held in any structure. They are rebuilt every cycle by comparing the counters, so lanes that arrive at the same address merge back into one group without further action. This works for any subset of the warp. A group whose lanes are all waiting is skipped, and it never holds back the other groups. The issue port carries the result of the issued instruction: a taken bit for each lane, one branch target, and an exit flag. A warp starts when it is launched at one address.

Top module: `sws_issue_sched`

## Requirements
- R1: After reset every lane is finished. `warp_done` is 1, `issue_valid` is 0, and `issue_pc` and `issue_mask` are 0.
- R2: A cycle with `launch` high sets every lane to running at `launch_pc`. It overrides the block, issue and exit inputs of that cycle. In the next cycle the issue is valid, with the full mask and `issue_pc` equal to `launch_pc`.
- R3: When the issue is valid, `issue_pc` is the lowest counter among running lanes. `issue_mask` bit i is 1 exactly when lane i is running and its counter equals `issue_pc`. Lanes that converge on one address therefore issue together.
- R4: A lane that is not in the issued mask keeps its counter. Blocking or unblocking a lane never changes its counter.
- R5: After an issue, each lane in the mask moves to `br_target` if its `br_taken` bit is set. Otherwise it moves to its counter plus 4, wrapping modulo 2^PC_W.
- R6: At a clock edge, `blk_set[i]` puts an unfinished lane i into waiting, and `blk_clr[i]` returns it to running. When both are high, set wins. Waiting lanes are never in the mask.
- R7: While at least one lane is running, `issue_valid` is 1, whatever the number of waiting lanes.
- R8: When no lane is running, `issue_valid` is 0, and `issue_pc` and `issue_mask` are 0.
- R9: An issue with `issue_exit` high finishes the masked lanes. A finished lane ignores the block inputs. `warp_done` is 1 exactly when all lanes are finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Start the warp with all lanes at `launch_pc` |
| launch_pc | input | PC_W | Start address |
| br_taken | input | LANES | Per-lane taken bit for the instruction issued this cycle |
| br_target | input | PC_W | Branch target of the instruction issued this cycle |
| issue_exit | input | 1 | The instruction issued this cycle ends the masked lanes |
| blk_set | input | LANES | Per-lane request to wait |
| blk_clr | input | LANES | Per-lane request to resume |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_pc | output | PC_W | Address of the issued instruction |
| issue_mask | output | LANES | Lanes that execute it |
| warp_done | output | 1 | All lanes finished |

## Verification
Directed sequences cover three things: an even/odd split with a later merge, which checks lowest-address selection and reconvergence; waiting lanes covering half of the warp and then all of it, which separates the R7 and R8 cases; and set and clear in the same cycle. A launch just below the top of the address space exposes the wrap of the sequential step. Random stimulus uses per-lane taken bits, targets drawn from a small set so that groups keep splitting and merging, sparse block and unblock requests, and rare exits. It relaunches the warp whenever it finishes, and every cycle is compared with a lane model kept in the bench.

// File: rtl/sws_pkg.sv
package sws_pkg;
  typedef enum logic [1:0] {
    ST_FIN  = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } lane_st_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/sws_lane.sv
module sws_lane
  import sws_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic [PC_W-1:0] launch_pc,
  input  logic            hit,
  input  logic            taken,
  input  logic [PC_W-1:0] target,
  input  logic            exit_req,
  input  logic            blk_set,
  input  logic            blk_clr,
  output logic [PC_W-1:0] pc,
  output logic            ready,
  output logic            fin
);
  lane_st_e st_q;
  logic [PC_W-1:0] pc_q;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] cur,
                                              input logic tk,
                                              input logic [PC_W-1:0] tgt);
    return tk ? tgt : cur + PC_W'(INSN_BYTES);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FIN;
      pc_q <= '0;
    end else if (launch) begin
      st_q <= ST_RUN;
      pc_q <= launch_pc;
    end else begin
      if (hit) pc_q <= step_pc(pc_q, taken, target);
      if (hit && exit_req) begin
        st_q <= ST_FIN;
      end else begin
        case (st_q)
          ST_RUN:  if (blk_set) st_q <= ST_WAIT;
          ST_WAIT: if (!blk_set && blk_clr) st_q <= ST_RUN;
          default: st_q <= st_q;
        endcase
      end
    end
  end

  assign pc    = pc_q;
  assign ready = (st_q == ST_RUN);
  assign fin   = (st_q == ST_FIN);
endmodule

// File: rtl/sws_pick.sv
module sws_pick #(
  parameter int unsigned LANES = 32,
  parameter int unsigned PC_W  = 32
) (
  input  logic [LANES-1:0]      ready,
  input  logic [LANES*PC_W-1:0] pc_flat,
  output logic                  valid,
  output logic [PC_W-1:0]       best_pc,
  output logic [LANES-1:0]      mask
);
  function automatic logic [PC_W-1:0] lane_pc(input logic [LANES*PC_W-1:0] f,
                                              input int unsigned idx);
    return f[idx*PC_W +: PC_W];
  endfunction

  always_comb begin
    logic found;
    logic [PC_W-1:0] best;
    found = 1'b0;
    best  = '0;
    for (int unsigned i = 0; i < LANES; i++) begin
      if (ready[i] && (!found || lane_pc(pc_flat, i) < best)) begin
        best  = lane_pc(pc_flat, i);
        found = 1'b1;
      end
    end
    valid   = found;
    best_pc = best;
    for (int unsigned i = 0; i < LANES; i++)
      mask[i] = ready[i] && (lane_pc(pc_flat, i) == best);
  end
endmodule

// File: rtl/sws_issue_sched.sv
module sws_issue_sched #(
  parameter int unsigned LANES = 32,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PC_W-1:0]  launch_pc,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic             issue_exit,
  input  logic [LANES-1:0] blk_set,
  input  logic [LANES-1:0] blk_clr,
  output logic             issue_valid,
  output logic [PC_W-1:0]  issue_pc,
  output logic [LANES-1:0] issue_mask,
  output logic             warp_done
);
  logic [LANES-1:0]      lane_ready;
  logic [LANES-1:0]      lane_fin;
  logic [LANES*PC_W-1:0] lane_pc_flat;
  logic [LANES-1:0]      lane_hit;
  logic                  pick_valid;
  logic [PC_W-1:0]       pick_pc;
  logic [LANES-1:0]      pick_mask;

  assign lane_hit = pick_valid ? pick_mask : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sws_lane #(.PC_W(PC_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .launch_pc(launch_pc),
      .hit      (lane_hit[g]),
      .taken    (br_taken[g]),
      .target   (br_target),
      .exit_req (issue_exit),
      .blk_set  (blk_set[g]),
      .blk_clr  (blk_clr[g]),
      .pc       (lane_pc_flat[g*PC_W +: PC_W]),
      .ready    (lane_ready[g]),
      .fin      (lane_fin[g])
    );
  end

  sws_pick #(.LANES(LANES), .PC_W(PC_W)) u_pick (
    .ready  (lane_ready),
    .pc_flat(lane_pc_flat),
    .valid  (pick_valid),
    .best_pc(pick_pc),
    .mask   (pick_mask)
  );

  assign issue_valid = pick_valid;
  assign issue_pc    = pick_valid ? pick_pc : '0;
  assign issue_mask  = lane_hit;
  assign warp_done   = &lane_fin;
endmodule

// File: rtl/sws_chk.sv
module sws_chk #(
  parameter int unsigned LANES = 32,
  parameter int unsigned PC_W  = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  launch,
  input logic [PC_W-1:0]       launch_pc,
  input logic                  issue_valid,
  input logic [PC_W-1:0]       issue_pc,
  input logic [LANES-1:0]      issue_mask,
  input logic                  warp_done,
  input logic [LANES-1:0]      lane_ready,
  input logic [LANES*PC_W-1:0] lane_pc_flat
);
  a_r1_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    warp_done |-> (!issue_valid && issue_mask == '0));

  a_r2_launch_full: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (issue_valid && issue_mask == {LANES{1'b1}} && issue_pc == $past(launch_pc)));

  a_r6_mask_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & ~lane_ready) == '0);

  a_r7_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ready) |-> issue_valid);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_pc == '0 && issue_mask == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r4_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !issue_mask[g]) |=> lane_pc_flat[g*PC_W +: PC_W] == $past(lane_pc_flat[g*PC_W +: PC_W]));

    a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      lane_ready[g] |-> issue_pc <= lane_pc_flat[g*PC_W +: PC_W]);
  end
endmodule

bind sws_issue_sched sws_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .launch      (launch),
  .launch_pc   (launch_pc),
  .issue_valid (issue_valid),
  .issue_pc    (issue_pc),
  .issue_mask  (issue_mask),
  .warp_done   (warp_done),
  .lane_ready  (lane_ready),
  .lane_pc_flat(lane_pc_flat)
);

// File: tb/sim_sws_issue_sched.sv
`timescale 1ns/1ps
module sim_sws_issue_sched;
  localparam int N = 32;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         launch = 1'b0;
  logic [W-1:0] launch_pc = '0;
  logic [N-1:0] br_taken = '0;
  logic [W-1:0] br_target = '0;
  logic         issue_exit = 1'b0;
  logic [N-1:0] blk_set = '0;
  logic [N-1:0] blk_clr = '0;
  logic         issue_valid;
  logic [W-1:0] issue_pc;
  logic [N-1:0] issue_mask;
  logic         warp_done;

  always #2.5 clk = ~clk;

  sws_issue_sched #(.LANES(N), .PC_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
    .br_taken(br_taken), .br_target(br_target), .issue_exit(issue_exit),
    .blk_set(blk_set), .blk_clr(blk_clr), .issue_valid(issue_valid),
    .issue_pc(issue_pc), .issue_mask(issue_mask), .warp_done(warp_done)
  );

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  logic [W-1:0] m_pc  [N];
  bit           m_blk [N];
  bit           m_fin [N];

  logic         e_valid;
  logic [W-1:0] e_pc;
  logic [N-1:0] e_mask;
  logic         e_done;

  function automatic void expect_now();
    bit any;
    logic [W-1:0] lo;
    any = 0; lo = '0; e_done = 1;
    for (int i = 0; i < N; i++) begin
      if (!m_fin[i]) e_done = 0;
      if (!m_fin[i] && !m_blk[i]) begin
        if (!any || m_pc[i] < lo) lo = m_pc[i];
        any = 1;
      end
    end
    e_valid = any;
    e_pc = any ? lo : '0;
    for (int i = 0; i < N; i++)
      e_mask[i] = any && !m_fin[i] && !m_blk[i] && (m_pc[i] == lo);
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (issue_valid !== e_valid || issue_pc !== e_pc ||
        issue_mask !== e_mask || warp_done !== e_done) begin
      errors++;
      $display("FAIL %s: got v=%0b pc=%h m=%h d=%0b exp v=%0b pc=%h m=%h d=%0b",
               tag, issue_valid, issue_pc, issue_mask, warp_done,
               e_valid, e_pc, e_mask, e_done);
    end
  endtask

  task automatic cyc(input string tag, input bit la, input logic [W-1:0] lpc,
                     input logic [N-1:0] tk, input logic [W-1:0] tgt, input bit ex,
                     input logic [N-1:0] st, input logic [N-1:0] cl);
    @(negedge clk);
    expect_now();
    compare(tag);
    launch = la; launch_pc = lpc; br_taken = tk; br_target = tgt;
    issue_exit = ex; blk_set = st; blk_clr = cl;
    for (int i = 0; i < N; i++) begin
      if (la) begin
        m_pc[i] = lpc; m_blk[i] = 0; m_fin[i] = 0;
      end else begin
        if (e_mask[i]) m_pc[i] = tk[i] ? tgt : m_pc[i] + 32'd4;
        if (e_mask[i] && ex) m_fin[i] = 1;
        else if (!m_fin[i]) m_blk[i] = st[i] | (m_blk[i] & ~cl[i]);
      end
    end
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, '0, '0, '0, 0, '0, '0);
  endtask

  localparam logic [N-1:0] EVEN = 32'h5555_5555;
  localparam logic [N-1:0] ODD  = 32'hAAAA_AAAA;
  localparam logic [N-1:0] LOW  = 32'h0000_FFFF;
  localparam logic [N-1:0] ALL  = 32'hFFFF_FFFF;

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_pc[i] = '0; m_blk[i] = 0; m_fin[i] = 1; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle("R1 reset state");
    // R1 block inputs on finished lanes ignored
    cyc("R1 idle", 0, '0, '0, '0, 0, ALL, '0);
    cyc("R2 launch", 1, 32'h100, '0, '0, 0, ALL, '0);
    // R3 R5 split: even lanes branch to 0x200
    cyc("R2 full mask", 0, '0, EVEN, 32'h200, 0, '0, '0);
    // odd lanes at 0x104 lowest; branch them to 0x200 -> merge
    cyc("R3 lowest group", 0, '0, ODD, 32'h200, 0, '0, '0);
    cyc("R3 merged", 0, '0, '0, '0, 0, LOW, '0);
    // R6 R7 low half waiting, high half progresses
    cyc("R7 half blocked", 0, '0, '0, '0, 0, '0, '0);
    cyc("R4 blocked lanes hold", 0, '0, '0, '0, 0, ~LOW, '0);
    cyc("R8 all waiting", 0, '0, '0, '0, 0, '0, LOW);
    // low half resumes at 0x204, behind the high half (0x20c)
    cyc("R4 resumed lowest", 0, '0, '0, '0, 0, '0, ~LOW);
    cyc("R3 regroup", 0, '0, '0, '0, 0, '0, '0);
    // R6 set and clear together: set wins
    cyc("R6 prep", 0, '0, '0, '0, 0, ALL, ALL);
    cyc("R6 set wins", 0, '0, '0, '0, 0, '0, ALL);
    cyc("R6 resumed", 0, '0, '0, '0, 0, '0, '0);
    // R9 partial exit then full exit
    cyc("R9 pre exit", 0, '0, ODD, 32'h400, 0, '0, '0);
    cyc("R9 exit even", 0, '0, '0, '0, 1, '0, '0);
    cyc("R9 odd remain", 0, '0, '0, '0, 0, '0, '0);
    cyc("R9 exit odd", 0, '0, '0, '0, 1, ALL, '0);
    cyc("R9 warp done", 0, '0, '0, '0, 0, '0, ALL);
    // R5 wrap, R2 launch overrides block and exit
    cyc("R9 done idle", 1, 32'hFFFF_FFFC, '0, '0, 1, ALL, '0);
    cyc("R5 top address", 0, '0, '0, '0, 0, '0, '0);
    idle("R5 wrapped to zero");

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] tk, st, cl;
      logic [W-1:0] tgt;
      bit ex, all_fin;
      all_fin = 1;
      for (int i = 0; i < N; i++) if (!m_fin[i]) all_fin = 0;
      tk  = $urandom() & $urandom();
      tgt = 32'h1000 + 32'(($urandom() % 8) * 4);
      st  = $urandom() & $urandom() & $urandom() & $urandom();
      cl  = $urandom() | $urandom();
      ex  = ($urandom() % 40) == 0;
      if (all_fin || ($urandom() % 500) == 0)
        cyc("R2/R9 random", 1, 32'h1000 + 32'(($urandom() % 4) * 4), tk, tgt, ex, st, cl);
      else
        cyc("R3/R5/R6/R7 random", 0, '0, tk, tgt, ex, st, cl);
    end
    idle("R3 final");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule